// File: doc/BRIEF.md
# Load/Store Bank Steering Predictor

When several small cores are joined to run one thread, the load/store queue is split into four banks, one per core. A memory operation belongs to the bank named by a two-bit field of its effective address. That field sits between the cache tag and the set index. The address is not known when the operation is dispatched, so this block guesses the bank from the instruction's PC. The guess comes from a small direct-mapped table with a confidence bit in each entry.

When the address has been computed, the block takes the real bank from it. If the real bank differs from the bank the operation was sent to, the block emits a one-cycle re-steer pulse. The pulse carries the operation's tag and the correct bank. The same resolve event also trains the table.

When the cores run separately (split mode), no prediction is made. Every operation stays on the local bank, and the two bank bits become the top bits of the cache set index, so each core can use its whole cache. Switching between the two modes wipes the table.

Top module: `msp_bank_steer`

## Requirements
- R1: After reset every table entry holds bank 0 with confidence clear, and `resteer_valid` is low.
- R2: In fused mode the real bank is address bits [14:13], and `res_index` is address bits [12:6] with its two upper bits zero (64-byte lines, 128 sets, 4 banks).
- R3: In fused mode `disp_bank` is combinationally the bank stored in the entry that `disp_pc` selects.
- R4: One cycle after a fused-mode resolve whose real bank differs from `res_pred_bank`, `resteer_valid` is high for that cycle only. In that cycle `resteer_tag` equals `res_tag` and `resteer_bank` equals the real bank. A resolve whose real bank matches `res_pred_bank` gives no pulse.
- R5: Training compares the real bank with the stored bank, not with `res_pred_bank`:
  - On a match, the entry's confidence is set.
  - On a mismatch with confidence set, only the confidence is cleared.
  - On a mismatch with confidence clear, the stored bank is replaced and the confidence stays clear.
- R6: In split mode `disp_bank` and `res_bank` are always the local bank (0 by default), no re-steer is raised, and the table is not written.
- R7: In split mode `res_index` is address bits [14:6], so the bank bits become the index's top two bits.
- R8: On the first clock edge after `fused_mode` changes value, every table entry returns to bank 0 with confidence clear.
- R9: The table entry is chosen by PC bits [7:2] only. PCs that differ only in other bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fused_mode | input | 1 | 1 = fused (banked, predicted), 0 = split (local bank); may change only while flushed |
| disp_pc | input | 32 | PC of the operation being dispatched |
| disp_bank | output | 2 | Predicted bank for the dispatched operation |
| res_valid | input | 1 | An operation's address is resolved this cycle |
| res_tag | input | 6 | Tag of the resolving operation |
| res_pc | input | 32 | PC of the resolving operation |
| res_addr | input | 32 | Effective address of the resolving operation |
| res_pred_bank | input | 2 | Bank the operation was steered to at dispatch |
| res_bank | output | 2 | Real bank of the resolving address |
| res_index | output | 9 | Cache set index of the resolving address |
| resteer_valid | output | 1 | One-cycle re-steer request |
| resteer_tag | output | 6 | Tag of the operation to re-steer |
| resteer_bank | output | 2 | Correct bank for the re-steered operation |

## Verification
The hardest condition to reach from the ports is a mismatch against an entry whose confidence bit is set. In that case the stored bank must survive.

Reaching it takes a sequence of resolves on a single PC:
1. A replacing miss.
2. A confirming hit.
3. A miss, which only weakens the entry.
4. A second miss, which finally replaces the bank.

After each step the stored bank is read back through `disp_pc`. Aliasing PCs, and a resolve whose `res_pred_bank` disagrees with the table, show that re-steer and training draw on different inputs. A mode round trip shows the wipe.

// File: rtl/msp_pkg.sv
package msp_pkg;

  // Operating mode of the steering logic.
  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_FUSED = 1'b1
  } steer_mode_e;

  // Outcome of one training event on a predictor entry.
  typedef enum logic [1:0] {
    TR_NONE    = 2'd0,
    TR_CONFIRM = 2'd1,
    TR_WEAKEN  = 2'd2,
    TR_REPLACE = 2'd3
  } train_e;

endpackage

// File: rtl/msp_addr_split.sv
// Splits the bank/set portion of an effective address by mode.
module msp_addr_split #(
  parameter int SET_W      = 7,
  parameter int BANK_W     = 2,
  parameter int LOCAL_BANK = 0,
  localparam int FIELD_W   = SET_W + BANK_W
) (
  input  logic               fused,
  input  logic [FIELD_W-1:0] field,
  output logic [BANK_W-1:0]  bank,
  output logic [FIELD_W-1:0] index
);

  function automatic logic [BANK_W-1:0] bank_bits(input logic [FIELD_W-1:0] f);
    return f[SET_W +: BANK_W];
  endfunction

  function automatic logic [FIELD_W-1:0] fused_index(input logic [FIELD_W-1:0] f);
    return {{BANK_W{1'b0}}, f[SET_W-1:0]};
  endfunction

  always_comb begin
    if (fused) begin
      bank  = bank_bits(field);
      index = fused_index(field);
    end else begin
      bank  = BANK_W'(LOCAL_BANK);
      index = field;
    end
  end

endmodule

// File: rtl/msp_pred_table.sv
// Direct-mapped bank predictor with one confidence bit per entry.
module msp_pred_table
  import msp_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int BANK_W   = 2,
  localparam int SLOT_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [BANK_W-1:0] rd_bank,
  input  logic              upd_en,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic [BANK_W-1:0] upd_bank
);

  function automatic train_e judge(input logic hit, input logic conf);
    if (hit)       return TR_CONFIRM;
    else if (conf) return TR_WEAKEN;
    else           return TR_REPLACE;
  endfunction

  logic [BANK_W-1:0] bank_q [DEPTH];
  logic [DEPTH-1:0]  conf_q;
  logic [BANK_W-1:0] cur_bank;
  logic              cur_conf;
  train_e            action;
  logic              ev_confirm, ev_weaken, ev_replace;
  logic              any_bank_set;

  assign rd_bank  = bank_q[rd_slot];
  assign cur_bank = bank_q[upd_slot];
  assign cur_conf = conf_q[upd_slot];

  always_comb begin
    action = TR_NONE;
    if (upd_en && !clr) action = judge(cur_bank == upd_bank, cur_conf);
  end

  assign ev_confirm = (action == TR_CONFIRM);
  assign ev_weaken  = (action == TR_WEAKEN);
  assign ev_replace = (action == TR_REPLACE);

  always_comb begin
    any_bank_set = 1'b0;
    for (int i = 0; i < DEPTH; i++) any_bank_set = any_bank_set | (|bank_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank_q[i] <= '0;
      conf_q <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) bank_q[i] <= '0;
      conf_q <= '0;
    end else begin
      case (action)
        TR_CONFIRM: conf_q[upd_slot] <= 1'b1;
        TR_WEAKEN:  conf_q[upd_slot] <= 1'b0;
        TR_REPLACE: begin
          bank_q[upd_slot] <= upd_bank;
          conf_q[upd_slot] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R5
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_confirm, ev_weaken, ev_replace}));

  // R5
  weaken_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_weaken |=> (bank_q[$past(upd_slot)] == $past(cur_bank)) && !conf_q[$past(upd_slot)]);

  // R5
  replace_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_replace |=> (bank_q[$past(upd_slot)] == $past(upd_bank)) && !conf_q[$past(upd_slot)]);

  // R5
  confirm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_confirm |=> conf_q[$past(upd_slot)]);

  // R8
  clr_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (conf_q == '0) && !any_bank_set);

  // R6
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !clr) |=> $stable(conf_q));

endmodule

// File: rtl/msp_resteer.sv
// Registers the one-cycle re-steer request.
module msp_resteer #(
  parameter int TAG_W  = 6,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [BANK_W-1:0] bank_in,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [BANK_W-1:0] bank
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      bank  <= '0;
    end else begin
      valid <= fire;
      if (fire) begin
        tag  <= tag_in;
        bank <= bank_in;
      end
    end
  end

endmodule

// File: rtl/msp_bank_steer.sv
// Top: predicts the load/store bank at dispatch and re-steers on a miss.
module msp_bank_steer
  import msp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 6,
  parameter int OFS_W      = 6,
  parameter int SET_W      = 7,
  parameter int NUM_BANKS  = 4,
  parameter int DEPTH      = 64,
  parameter int PC_LSB     = 2,
  parameter int LOCAL_BANK = 0,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int SLOT_W    = $clog2(DEPTH),
  localparam int FIELD_W   = SET_W + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fused_mode,
  input  logic [PC_W-1:0]    disp_pc,
  output logic [BANK_W-1:0]  disp_bank,
  input  logic               res_valid,
  input  logic [TAG_W-1:0]   res_tag,
  input  logic [PC_W-1:0]    res_pc,
  input  logic [ADDR_W-1:0]  res_addr,
  input  logic [BANK_W-1:0]  res_pred_bank,
  output logic [BANK_W-1:0]  res_bank,
  output logic [FIELD_W-1:0] res_index,
  output logic               resteer_valid,
  output logic [TAG_W-1:0]   resteer_tag,
  output logic [BANK_W-1:0]  resteer_bank
);

  function automatic logic [SLOT_W-1:0] slot_of(input logic [PC_W-1:0] pc);
    return pc[PC_LSB +: SLOT_W];
  endfunction

  steer_mode_e       mode_q;
  logic              mode_chg;
  logic              is_fused;
  logic              train_en;
  logic              mispredict;
  logic [BANK_W-1:0] tbl_bank;

  wire unused_bits = ^{disp_pc[PC_W-1:PC_LSB+SLOT_W], disp_pc[PC_LSB-1:0],
                       res_pc[PC_W-1:PC_LSB+SLOT_W], res_pc[PC_LSB-1:0],
                       res_addr[ADDR_W-1:OFS_W+FIELD_W], res_addr[OFS_W-1:0]};

  assign is_fused   = (fused_mode == MODE_FUSED);
  assign mode_chg   = (steer_mode_e'(fused_mode) != mode_q);
  assign train_en   = res_valid && is_fused && !mode_chg;
  assign mispredict = train_en && (res_bank != res_pred_bank);
  assign disp_bank  = is_fused ? tbl_bank : BANK_W'(LOCAL_BANK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_FUSED;
    else        mode_q <= steer_mode_e'(fused_mode);
  end

  msp_addr_split #(
    .SET_W(SET_W), .BANK_W(BANK_W), .LOCAL_BANK(LOCAL_BANK)
  ) u_split (
    .fused (is_fused),
    .field (res_addr[OFS_W +: FIELD_W]),
    .bank  (res_bank),
    .index (res_index)
  );

  msp_pred_table #(
    .DEPTH(DEPTH), .BANK_W(BANK_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mode_chg),
    .rd_slot  (slot_of(disp_pc)),
    .rd_bank  (tbl_bank),
    .upd_en   (train_en),
    .upd_slot (slot_of(res_pc)),
    .upd_bank (res_bank)
  );

  msp_resteer #(
    .TAG_W(TAG_W), .BANK_W(BANK_W)
  ) u_resteer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (mispredict),
    .tag_in  (res_tag),
    .bank_in (res_bank),
    .valid   (resteer_valid),
    .tag     (resteer_tag),
    .bank    (resteer_bank)
  );

  // R4
  resteer_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resteer_valid |-> $past(res_valid) && (resteer_bank != $past(res_pred_bank)));

  // R4
  resteer_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resteer_valid |-> (resteer_tag == $past(res_tag)));

  // R6
  split_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fused_mode) |-> !resteer_valid);

endmodule

// File: tb/tb_msp_bank_steer.sv
`timescale 1ns/100ps
module tb_msp_bank_steer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fused_mode;
  logic [31:0] disp_pc;
  logic [1:0]  disp_bank;
  logic        res_valid;
  logic [5:0]  res_tag;
  logic [31:0] res_pc;
  logic [31:0] res_addr;
  logic [1:0]  res_pred_bank;
  logic [1:0]  res_bank;
  logic [8:0]  res_index;
  logic        resteer_valid;
  logic [5:0]  resteer_tag;
  logic [1:0]  resteer_bank;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  msp_bank_steer dut (
    .clk(clk), .rst_n(rst_n), .fused_mode(fused_mode),
    .disp_pc(disp_pc), .disp_bank(disp_bank),
    .res_valid(res_valid), .res_tag(res_tag), .res_pc(res_pc),
    .res_addr(res_addr), .res_pred_bank(res_pred_bank),
    .res_bank(res_bank), .res_index(res_index),
    .resteer_valid(resteer_valid), .resteer_tag(resteer_tag),
    .resteer_bank(resteer_bank)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] addr;
    logic [1:0]  pred;
    logic        rs;
    logic [1:0]  rs_bank;
    logic [31:0] probe_pc;
    logic [1:0]  probe_bank;
  } vec_t;

  // Bank field is addr[14:13]; entry is pc[7:2].
  localparam vec_t VECS [7] = '{
    '{32'h0000_0104, 32'h0000_4000, 2'd0, 1'b1, 2'd2, 32'h0000_0104, 2'd2}, // replace 0->2
    '{32'h0000_0104, 32'h0000_4040, 2'd2, 1'b0, 2'd0, 32'h0000_0104, 2'd2}, // confirm
    '{32'h0000_0104, 32'h0000_6000, 2'd2, 1'b1, 2'd3, 32'h0000_0104, 2'd2}, // weaken only
    '{32'h0000_0104, 32'h0000_2000, 2'd2, 1'b1, 2'd1, 32'h0000_0104, 2'd1}, // replace 2->1
    '{32'h0000_0504, 32'h0000_1FC0, 2'd1, 1'b1, 2'd0, 32'h0000_0104, 2'd0}, // alias slot 1
    '{32'h0000_0108, 32'h0000_6000, 2'd3, 1'b0, 2'd0, 32'h0000_0108, 2'd3}, // pred ok, table trains
    '{32'h0000_010B, 32'hFFFF_E000, 2'd3, 1'b0, 2'd0, 32'h0000_0308, 2'd3}  // low/high pc bits
  };

  vec_t v;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the capturing edge.
  task automatic resolve(input logic [5:0] tag, input logic [31:0] pc,
                         input logic [31:0] addr, input logic [1:0] pred);
    res_valid = 1'b1; res_tag = tag; res_pc = pc; res_addr = addr; res_pred_bank = pred;
    @(posedge clk);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fused_mode = 1'b1; disp_pc = 32'h104;
    res_valid = 1'b0; res_tag = '0; res_pc = '0; res_addr = '0; res_pred_bank = '0;
    repeat (3) @(negedge clk);
    check("R1 resteer_valid in reset", resteer_valid, 1'b0);
    check("R1 disp_bank in reset", disp_bank, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 disp_bank after reset", disp_bank, 2'd0);

    // Vector walk: R3 R4 R5 R9
    for (int i = 0; i < 7; i++) begin
      v = VECS[i];
      resolve(6'(i), v.pc, v.addr, v.pred);
      check("R4 resteer_valid", resteer_valid, v.rs);
      if (v.rs) begin
        check("R4 resteer_bank", resteer_bank, v.rs_bank);
        check("R4 resteer_tag", resteer_tag, 32'(i));
      end
      disp_pc = v.probe_pc;
      #1;
      check("R3 R5 R9 stored bank", disp_bank, v.probe_bank);
    end

    // R2 fused field decode
    res_addr = 32'h0000_7FC0; #1;
    check("R2 fused bank", res_bank, 2'd3);
    check("R2 fused index", res_index, 9'h07F);
    res_addr = 32'h0000_4040; #1;
    check("R2 fused bank b", res_bank, 2'd2);
    check("R2 fused index b", res_index, 9'h001);

    // R4 back-to-back re-steers, then single-cycle drop
    @(negedge clk);
    res_valid = 1'b1; res_tag = 6'd10; res_pc = 32'h200; res_addr = 32'h2000; res_pred_bank = 2'd0;
    @(posedge clk); @(negedge clk);
    check("R4 first pulse", resteer_valid, 1'b1);
    check("R4 first tag", resteer_tag, 6'd10);
    check("R4 first bank", resteer_bank, 2'd1);
    res_tag = 6'd11; res_pc = 32'h204; res_addr = 32'h4000;
    @(posedge clk); @(negedge clk);
    check("R4 second pulse", resteer_valid, 1'b1);
    check("R4 second tag", resteer_tag, 6'd11);
    check("R4 second bank", resteer_bank, 2'd2);
    res_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R4 pulse ends", resteer_valid, 1'b0);

    // R6 R7 split mode
    fused_mode = 1'b0;
    disp_pc = 32'h108; res_addr = 32'h0000_7FC0; #1;
    check("R6 split disp_bank local", disp_bank, 2'd0);
    check("R6 split res_bank local", res_bank, 2'd0);
    check("R7 split index", res_index, 9'h1FF);
    @(posedge clk); @(negedge clk);
    resolve(6'd5, 32'h108, 32'h6000, 2'd2);
    check("R6 split no resteer", resteer_valid, 1'b0);

    // R8 return to fused: table wiped (slot 2 held bank 3)
    fused_mode = 1'b1;
    @(posedge clk); @(negedge clk);
    disp_pc = 32'h108; #1;
    check("R8 wiped entry", disp_bank, 2'd0);
    resolve(6'd6, 32'h108, 32'h6000, 2'd3);
    check("R8 no resteer on match", resteer_valid, 1'b0);
    disp_pc = 32'h108; #1;
    check("R8 R5 replace after wipe", disp_bank, 2'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule